// File: doc/BRIEF.md
# Stop-Mode Clock Enable Sequencer

This block decides when a microcontroller may enter its low-power stop mode and then walks the clock enables down and back up in a fixed order. Software asks for stop through a small register write port. The block first checks that the clock configuration permits stopping. It then waits until the CPU no longer holds the internal bus. After that it removes the CPU clock enable, then the bus clock enable, and finally the peripheral clock enable together with the oscillator enable. Every step takes exactly one reference-clock cycle.

The block leaves stop mode when a peripheral interrupt is pending and its enable bit is set. It first turns the oscillator back on and counts out a programmable stabilization delay. It then restores the peripheral, bus and CPU enables in that order, again one cycle per step. Reset returns everything to the running state at once. The sequencer runs on a free-running reference clock that stays alive through stop mode. The four enable outputs come straight from flip-flops, so they are free of glitches and can drive clock gating cells directly.

Register map, with byte-wide data:
- Address 0 is control. Bit 7 is the stop request, which reads back as the stop flag. Bit 0 is the sticky error flag, and writing 1 to it clears the flag.
- Address 1 is the gear configuration. Bits [1:0] hold the CPU gear, bits [3:2] the peripheral gear, and bit 4 the clock-halving select.
- Addresses 2 and 3 hold the low and high bytes of the 16-bit stabilization count.

Top module: `stop_clk_seq`

## Requirements
- R1: After reset the CPU, bus and peripheral clock enables and the oscillator enable are all 1. Control reads 0x00, gear reads 0x00, and the stabilization count reads its reset value of 0x0010.
- R2: A write to address 0 with bit 7 set, while the block is running, is accepted only when gear bit 4 is 1 and gear bits [1:0] equal gear bits [3:2]. An accepted request makes control bit 7 read back as 1.
- R3: A request that fails the check in R2 leaves control bit 7 at 0 and sets control bit 0. All enables stay at 1.
- R4: The error flag in control bit 0 holds its value until a write to address 0 with bit 7 clear and bit 0 set clears it.
- R5: After an accepted request, no enable changes while the bus-busy input is high. The CPU enable falls on the first clock edge at which bus-busy is seen low.
- R6: Shutdown order is fixed. The CPU enable falls first. The bus enable falls one cycle later. The peripheral enable and the oscillator enable fall together one cycle after that.
- R7: Once fully stopped, the block wakes only on an interrupt whose pending bit and enable bit are both 1. A pending interrupt whose enable bit is 0 has no effect.
- R8: Wake order is fixed. The oscillator enable rises on the edge at which the wake is seen. The peripheral enable rises a stabilization delay later, the bus enable one cycle after that, and the CPU enable one cycle after that. The stop flag clears on the same edge as the CPU enable.
- R9: The stabilization count is programmable through addresses 2 and 3 and reads back unchanged. With count N, the peripheral enable rises exactly N+1 cycles after the oscillator enable.
- R10: Reset asserted in any state sets all four enables to 1 and clears the stop flag.
- R11: A write to address 0 with bit 7 set while a shutdown or wake sequence is in progress has no effect. The error flag is not set and the sequence is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| bus_busy | input | 1 | CPU is still using the internal bus |
| irq_pend | input | 4 | Peripheral interrupt pending bits |
| irq_ena | input | 4 | Peripheral interrupt enable bits |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Internal bus clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
The bench rejects stop requests in two ways: with the halving bit clear, and with mismatched gears. A design that accepted either would drop the clocks with a bad gear setting. It holds bus-busy high after an accepted request and checks that the CPU enable stays up until the bus is released. It also injects a second request in the middle of the sequence, which an unguarded design would wrongly flag as an error.

Shutdown and wake are sampled cycle by cycle. This catches swapped or merged steps and an oscillator that is not tied to the peripheral step. The stabilization count is run at 3 and at 0, which exposes an off-by-one in the delay. A pending interrupt with its enable cleared must leave the block stopped. Reset is asserted in the middle of stop mode.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTL    = 2'd0;
    localparam logic [ADDR_W-1:0] A_GEAR   = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAB_L = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAB_H = 2'd3;

    // control bit positions
    localparam int unsigned B_STOP  = 7;
    localparam int unsigned B_ERR   = 0;

    // gear field positions
    localparam int unsigned GEAR_W  = 2;
    localparam int unsigned B_CGEAR = 0;
    localparam int unsigned B_PGEAR = 2;
    localparam int unsigned B_HALVE = 4;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_WAIT_BUS,
        ST_CPU_OFF,
        ST_BUS_OFF,
        ST_STOPPED,
        ST_WAKE,
        ST_PER_ON,
        ST_BUS_ON
    } seq_state_e;

endpackage

// File: rtl/sc_regs.sv
module sc_regs
    import sc_pkg::*;
#(
    parameter int unsigned STAB_W   = 16,
    parameter logic [STAB_W-1:0] STAB_RST = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              seq_idle,
    input  logic              seq_done,
    output logic              stop_go,
    output logic [STAB_W-1:0] stab_val
);

    localparam int unsigned HI_W = STAB_W - DATA_W;

    typedef struct packed {
        logic              stop;
        logic              err;
        logic [GEAR_W-1:0] cgear;
        logic [GEAR_W-1:0] pgear;
        logic              halve;
        logic [STAB_W-1:0] stab;
    } regs_t;

    regs_t r_d, r_q;
    logic  cfg_ok;

    // stop is only legal with halving selected and equal gears
    assign cfg_ok = r_q.halve && (r_q.cgear == r_q.pgear);

    always_comb begin
        r_d     = r_q;
        stop_go = 1'b0;
        if (wr_en) begin
            unique case (wr_addr)
                A_CTL: begin
                    if (wr_data[B_STOP]) begin
                        if (seq_idle) begin
                            if (cfg_ok) begin
                                r_d.stop = 1'b1;
                                stop_go  = 1'b1;
                            end else begin
                                r_d.err  = 1'b1;
                            end
                        end
                    end else if (wr_data[B_ERR]) begin
                        r_d.err = 1'b0;
                    end
                end
                A_GEAR: begin
                    r_d.cgear = wr_data[B_CGEAR +: GEAR_W];
                    r_d.pgear = wr_data[B_PGEAR +: GEAR_W];
                    r_d.halve = wr_data[B_HALVE];
                end
                A_STAB_L: r_d.stab[DATA_W-1:0]      = wr_data;
                A_STAB_H: r_d.stab[STAB_W-1:DATA_W] = wr_data[HI_W-1:0];
                default: ;
            endcase
        end
        if (seq_done) begin
            r_d.stop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.stab  <= STAB_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTL: begin
                rd_data[B_STOP] = r_q.stop;
                rd_data[B_ERR]  = r_q.err;
            end
            A_GEAR: begin
                rd_data[B_CGEAR +: GEAR_W] = r_q.cgear;
                rd_data[B_PGEAR +: GEAR_W] = r_q.pgear;
                rd_data[B_HALVE]           = r_q.halve;
            end
            A_STAB_L: rd_data         = r_q.stab[DATA_W-1:0];
            A_STAB_H: rd_data[HI_W-1:0] = r_q.stab[STAB_W-1:DATA_W];
            default: rd_data = '0;
        endcase
    end

    assign stab_val = r_q.stab;

    // R2
    stop_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.stop) |-> $past(cfg_ok));

    // R3
    err_on_bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.err) |-> ($past(!cfg_ok) && !r_q.stop));

    // R8
    stop_clr_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.stop) |-> $past(seq_done));

endmodule

// File: rtl/sc_stab_cnt.sv
module sc_stab_cnt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R9
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/sc_fsm.sv
module sc_fsm
    import sc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_go,
    input  logic bus_busy,
    input  logic wake,
    input  logic cnt_zero,
    output logic cnt_load,
    output logic seq_idle,
    output logic seq_done,
    output logic cpu_en,
    output logic bus_en,
    output logic per_en,
    output logic osc_en
);

    typedef struct packed {
        seq_state_e st;
        logic       cpu;
        logic       bus;
        logic       per;
        logic       osc;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        cnt_load = 1'b0;
        unique case (f_q.st)
            ST_RUN:      if (stop_go) f_d.st = ST_WAIT_BUS;
            ST_WAIT_BUS: if (!bus_busy) begin
                             f_d.st  = ST_CPU_OFF;
                             f_d.cpu = 1'b0;
                         end
            ST_CPU_OFF:  begin
                             f_d.st  = ST_BUS_OFF;
                             f_d.bus = 1'b0;
                         end
            ST_BUS_OFF:  begin
                             f_d.st  = ST_STOPPED;
                             f_d.per = 1'b0;
                             f_d.osc = 1'b0;
                         end
            ST_STOPPED:  if (wake) begin
                             f_d.st   = ST_WAKE;
                             f_d.osc  = 1'b1;
                             cnt_load = 1'b1;
                         end
            ST_WAKE:     if (cnt_zero) begin
                             f_d.st  = ST_PER_ON;
                             f_d.per = 1'b1;
                         end
            ST_PER_ON:   begin
                             f_d.st  = ST_BUS_ON;
                             f_d.bus = 1'b1;
                         end
            ST_BUS_ON:   begin
                             f_d.st  = ST_RUN;
                             f_d.cpu = 1'b1;
                         end
            default:     f_d = '{st: ST_RUN, cpu: 1'b1, bus: 1'b1, per: 1'b1, osc: 1'b1};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_RUN, cpu: 1'b1, bus: 1'b1, per: 1'b1, osc: 1'b1};
        else        f_q <= f_d;
    end

    assign seq_idle = (f_q.st == ST_RUN);
    assign seq_done = (f_q.st == ST_BUS_ON);
    assign cpu_en   = f_q.cpu;
    assign bus_en   = f_q.bus;
    assign per_en   = f_q.per;
    assign osc_en   = f_q.osc;

    // R5
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_WAIT_BUS && bus_busy) |=> (cpu_en && bus_en && per_en));

    // R6
    bus_after_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_en) |-> (!cpu_en && $past(!cpu_en)));

    // R6
    per_after_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(per_en) |-> (!bus_en && $past(!bus_en) && !osc_en));

    // R6
    osc_covers_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !per_en);

    // R8
    cpu_last_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_en) |-> (bus_en && per_en && osc_en));

    // R8
    bus_after_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_en) |-> $past(per_en));

endmodule

// File: rtl/stop_clk_seq.sv
module stop_clk_seq
    import sc_pkg::*;
#(
    parameter int unsigned NIRQ     = 4,
    parameter int unsigned STAB_W   = 16,
    parameter logic [STAB_W-1:0] STAB_RST = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              bus_busy,
    input  logic [NIRQ-1:0]   irq_pend,
    input  logic [NIRQ-1:0]   irq_ena,
    output logic              cpu_clk_en,
    output logic              bus_clk_en,
    output logic              per_clk_en,
    output logic              osc_en
);

    logic              stop_go;
    logic              seq_idle;
    logic              seq_done;
    logic [STAB_W-1:0] stab_val;
    logic              cnt_load;
    logic              cnt_zero;
    logic              wake;

    assign wake = |(irq_pend & irq_ena);

    sc_regs #(
        .STAB_W   (STAB_W),
        .STAB_RST (STAB_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .seq_idle (seq_idle),
        .seq_done (seq_done),
        .stop_go  (stop_go),
        .stab_val (stab_val)
    );

    sc_stab_cnt #(
        .W (STAB_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (stab_val),
        .zero     (cnt_zero)
    );

    sc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_go  (stop_go),
        .bus_busy (bus_busy),
        .wake     (wake),
        .cnt_zero (cnt_zero),
        .cnt_load (cnt_load),
        .seq_idle (seq_idle),
        .seq_done (seq_done),
        .cpu_en   (cpu_clk_en),
        .bus_en   (bus_clk_en),
        .per_en   (per_clk_en),
        .osc_en   (osc_en)
    );

    // R7
    no_wake_without_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!osc_en) && !wake && !osc_en) |=> !osc_en);

endmodule

// File: tb/tb_stop_clk_seq.sv
module tb_stop_clk_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       bus_busy = 1'b0;
    logic [3:0] irq_pend = '0;
    logic [3:0] irq_ena = '0;
    logic       cpu_clk_en, bus_clk_en, per_clk_en, osc_en;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    stop_clk_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .bus_busy   (bus_busy),
        .irq_pend   (irq_pend),
        .irq_ena    (irq_ena),
        .cpu_clk_en (cpu_clk_en),
        .bus_clk_en (bus_clk_en),
        .per_clk_en (per_clk_en),
        .osc_en     (osc_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // enables packed as {cpu,bus,per,osc}
    function automatic logic [3:0] ens();
        return {cpu_clk_en, bus_clk_en, per_clk_en, osc_en};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 enables", ens(), 4'hF);
        rd(2'd0, v); chk("R1 ctl", v, 8'h00);
        rd(2'd1, v); chk("R1 gear", v, 8'h00);
        rd(2'd2, v); chk("R1 stab lo", v, 8'h10);
        rd(2'd3, v); chk("R1 stab hi", v, 8'h00);
    endtask

    task automatic t_reject(input logic [7:0] gear, input string tag);
        logic [7:0] v;
        wr(2'd1, gear);
        wr(2'd0, 8'h80);
        rd(2'd0, v); chk({"R3 ctl ", tag}, v, 8'h01);
        cyc(4);
        chk({"R3 enables ", tag}, ens(), 4'hF);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk({"R4 sticky ", tag}, v, 8'h01);
        wr(2'd0, 8'h01);
        rd(2'd0, v); chk({"R4 cleared ", tag}, v, 8'h00);
    endtask

    task automatic t_stab_prog;
        logic [7:0] v;
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h3C);
        rd(2'd2, v); chk("R9 stab lo", v, 8'hA5);
        rd(2'd3, v); chk("R9 stab hi", v, 8'h3C);
    endtask

    task automatic t_full_cycle;
        logic [7:0] v;
        wr(2'd1, 8'h15);
        wr(2'd2, 8'h03);
        wr(2'd3, 8'h00);
        bus_busy = 1'b1;
        wr(2'd0, 8'h80);
        rd(2'd0, v); chk("R2 stop accepted", v, 8'h80);
        cyc(3);
        chk("R5 held while busy", ens(), 4'hF);
        // R11: request during sequence ignored, even with bad gear
        wr(2'd1, 8'h05);
        wr(2'd0, 8'h80);
        rd(2'd0, v); chk("R11 no error mid-sequence", v, 8'h80);
        chk("R11 sequence undisturbed", ens(), 4'hF);
        wr(2'd1, 8'h15);
        bus_busy = 1'b0;
        @(negedge clk); chk("R5 cpu off after bus free", ens(), 4'b0111);
        @(negedge clk); chk("R6 bus off", ens(), 4'b0011);
        @(negedge clk); chk("R6 per+osc off", ens(), 4'b0000);
        irq_pend = 4'b0100; irq_ena = 4'b0010;
        cyc(5);
        chk("R7 unenabled irq ignored", ens(), 4'b0000);
        irq_ena = 4'b0110;
        @(negedge clk); chk("R8 osc on first", ens(), 4'b0001);
        irq_pend = '0; irq_ena = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); chk("R9 stab wait", ens(), 4'b0001);
        end
        @(negedge clk); chk("R9 per on after N+1", ens(), 4'b0011);
        rd(2'd0, v); chk("R8 stop still set", v, 8'h80);
        @(negedge clk); chk("R8 bus on", ens(), 4'b0111);
        @(negedge clk); chk("R8 cpu on", ens(), 4'b1111);
        rd(2'd0, v); chk("R8 stop cleared", v, 8'h00);
    endtask

    task automatic t_stab_zero;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h80);
        cyc(3);
        chk("R6 stopped (stab0)", ens(), 4'b0000);
        irq_pend = 4'b0001; irq_ena = 4'b0001;
        @(negedge clk); chk("R8 osc on (stab0)", ens(), 4'b0001);
        irq_pend = '0; irq_ena = '0;
        @(negedge clk); chk("R9 per on after 1 (stab0)", ens(), 4'b0011);
        cyc(2);
        chk("R8 all on (stab0)", ens(), 4'b1111);
    endtask

    task automatic t_reset_in_stop;
        logic [7:0] v;
        wr(2'd0, 8'h80);
        cyc(3);
        chk("R10 precondition stopped", ens(), 4'b0000);
        rst_n = 1'b0;
        #1;
        chk("R10 enables after reset", ens(), 4'hF);
        rd(2'd0, v); chk("R10 stop cleared", v, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(3);
        chk("R10 stays running", ens(), 4'hF);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject(8'h05, "halve=0");
        t_reject(8'h16, "gear mismatch");
        t_stab_prog();
        t_full_cycle();
        t_stab_zero();
        t_reset_in_stop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule